// File: doc/BRIEF.md
# Packet Error Code Generator and Checker

This block keeps a running CRC-8 over every byte of a bus transaction. That includes each address byte with its read/write bit, and any address byte repeated after a restart. A bit-level bus controller sits beside it. That controller pulses a clear at the start of each message and then strobes in every byte it puts on the wire or takes off the wire, one byte per cycle at most. It marks the final byte with an end flag.

The block has a transmit mode and a receive mode:

- **Transmit:** the end flag goes with the last payload byte. The held CRC is then the error-code byte that the controller appends to the message.
- **Receive:** the end flag goes with the error-code byte received from the far side. The block reports a pass when the CRC over the whole message, including that byte, comes out as zero.

Error checking can be switched off. In that case the running value stays at zero and every message is reported as passing.

A small sequencer tracks the message:

- **ST_IDLE:** the message is cleared and no byte has arrived yet.
- **ST_RUN:** bytes are being accumulated.
- **ST_HOLD:** the end marker has been seen, and the result is frozen until the next clear.

The transitions are:

- IDLE→RUN: a byte arrives without the end flag.
- IDLE→HOLD and RUN→HOLD: a byte arrives with the end flag.
- Any state→IDLE: a clear arrives alone.
- Any state→RUN or HOLD: a clear arrives together with a byte. The byte starts the new message.
- HOLD stays in HOLD when a byte arrives without a clear.

Top module: `smbus_pec_engine`

## Requirements
- R1: While reset is asserted and after its release, `crc_o` is 0x00, `done_o` is 0 and `pec_ok_o` is 0.
- R2: With checking on, each accepted byte updates `crc_o` in the following cycle to the CRC-8 of all accepted bytes of the message. The CRC uses generator 0x07 (x^8+x^2+x+1), zero start value, most significant bit first, no reflection and no final XOR. Address bytes, including repeated ones, are covered like any other byte.
- R3: A clear strobe without a byte strobe sets `crc_o` to 0x00 and `done_o` to 0 in the next cycle.
- R4: When clear and a byte strobe arrive in the same cycle, the clear wins and the byte becomes the first byte of the new message: `crc_o` becomes CRC-8(0, byte).
- R5: A byte strobe with the end flag set causes `done_o` to be 1 from the next cycle on, until a clear.
- R6: While `done_o` is 1, byte strobes without a clear are ignored: `crc_o`, `done_o` and `pec_ok_o` do not change.
- R7: In transmit mode (`rx_mode_i`=0) with checking on, after the end byte `crc_o` holds the error-code byte to append and `pec_ok_o` is 1.
- R8: In receive mode (`rx_mode_i`=1) with checking on, after the end byte `pec_ok_o` is 1 exactly when the CRC over all bytes, including the received error-code byte, is 0x00.
- R9: With checking off (`pec_en_i`=0), `crc_o` stays 0x00 through the message and `pec_ok_o` is 1 after the end byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clear_i | input | 1 | Start-of-message clear strobe |
| byte_vld_i | input | 1 | Byte strobe |
| byte_i | input | 8 | Byte seen on the wire |
| last_i | input | 1 | Marks the strobed byte as the final byte of the message |
| pec_en_i | input | 1 | 1 = error checking on |
| rx_mode_i | input | 1 | 1 = receive/check, 0 = transmit/generate |
| crc_o | output | 8 | Running or final CRC value |
| done_o | output | 1 | Message ended; result held |
| pec_ok_o | output | 1 | Pass flag, valid while `done_o` is 1 |

## Verification
The clear strobe and a byte strobe can fall in the same cycle. The bench provokes this in three situations:

- right after a held result;
- in the middle of a message;
- together with the end flag, so that a one-byte message starts and ends at once.

In each case the expected `crc_o` is the CRC of that byte alone from a zero start, and the expected `done_o` follows the end flag. A byte strobe arriving while the result is held is a second collision, between the freeze and the update. It is judged by `crc_o`, `done_o` and `pec_ok_o` staying unchanged.

// File: rtl/smbus_pec_pkg.sv
package smbus_pec_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_HOLD = 2'd2
    } pec_state_e;

    localparam int unsigned PEC_CRC_W  = 8;
    localparam int unsigned PEC_DATA_W = 8;
    localparam logic [PEC_CRC_W-1:0] PEC_POLY = 8'h07;

endpackage

// File: rtl/pec_byte_update.sv
module pec_byte_update #(
    parameter int unsigned CRC_W  = 8,
    parameter int unsigned DATA_W = 8,
    parameter logic [CRC_W-1:0] POLY = 8'h07
) (
    input  logic [CRC_W-1:0]  seed_i,
    input  logic [DATA_W-1:0] data_i,
    output logic [CRC_W-1:0]  next_o
);

    // one stage per data bit, most significant bit first
    logic [CRC_W-1:0] stage [DATA_W+1];

    assign stage[0] = seed_i;

    for (genvar g = 0; g < DATA_W; g++) begin : g_bit
        logic feedback;
        assign feedback = stage[g][CRC_W-1] ^ data_i[DATA_W-1-g];
        assign stage[g+1] = {stage[g][CRC_W-2:0], 1'b0} ^ (feedback ? POLY : '0);
    end

    assign next_o = stage[DATA_W];

endmodule

// File: rtl/pec_seq_fsm.sv
module pec_seq_fsm
    import smbus_pec_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    input  logic byte_vld_i,
    input  logic last_i,
    output logic accept_o,
    output logic done_o
);

    pec_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        if (clear_i) begin
            if (byte_vld_i) begin
                state_d = last_i ? ST_HOLD : ST_RUN;
            end else begin
                state_d = ST_IDLE;
            end
        end else begin
            unique case (state_q)
                ST_IDLE: if (byte_vld_i) state_d = last_i ? ST_HOLD : ST_RUN;
                ST_RUN:  if (byte_vld_i && last_i) state_d = ST_HOLD;
                ST_HOLD: state_d = ST_HOLD;
                default: state_d = ST_IDLE;
            endcase
        end
    end

    always_comb begin
        accept_o = 1'b0;
        done_o   = 1'b0;
        unique case (state_q)
            ST_IDLE: accept_o = byte_vld_i;
            ST_RUN:  accept_o = byte_vld_i;
            ST_HOLD: begin
                accept_o = byte_vld_i && clear_i;
                done_o   = 1'b1;
            end
            default: accept_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/pec_crc_reg.sv
module pec_crc_reg #(
    parameter int unsigned CRC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             accept_i,
    input  logic             last_i,
    input  logic             en_i,
    input  logic             rx_i,
    input  logic [CRC_W-1:0] upd_i,
    output logic [CRC_W-1:0] seed_o,
    output logic [CRC_W-1:0] crc_o,
    output logic             ok_o
);

    logic [CRC_W-1:0] crc_q;
    logic             ok_q;
    logic             verdict;

    // a clear restarts from zero, even for a byte in the same cycle
    assign seed_o = clear_i ? '0 : crc_q;

    always_comb begin
        if (!en_i || !rx_i) begin
            verdict = 1'b1;
        end else begin
            verdict = (upd_i == '0);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            crc_q <= '0;
            ok_q  <= 1'b0;
        end else begin
            if (accept_i && en_i) begin
                crc_q <= upd_i;
            end else begin
                crc_q <= seed_o;
            end
            if (accept_i) begin
                ok_q <= last_i ? verdict : 1'b0;
            end else if (clear_i) begin
                ok_q <= 1'b0;
            end
        end
    end

    assign crc_o = crc_q;
    assign ok_o  = ok_q;

endmodule

// File: rtl/smbus_pec_engine.sv
module smbus_pec_engine
    import smbus_pec_pkg::*;
#(
    parameter int unsigned CRC_W  = PEC_CRC_W,
    parameter int unsigned DATA_W = PEC_DATA_W,
    parameter logic [CRC_W-1:0] POLY = PEC_POLY
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic              byte_vld_i,
    input  logic [DATA_W-1:0] byte_i,
    input  logic              last_i,
    input  logic              pec_en_i,
    input  logic              rx_mode_i,
    output logic [CRC_W-1:0]  crc_o,
    output logic              done_o,
    output logic              pec_ok_o
);

    logic             accept;
    logic [CRC_W-1:0] seed;
    logic [CRC_W-1:0] upd;

    pec_seq_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear_i    (clear_i),
        .byte_vld_i (byte_vld_i),
        .last_i     (last_i),
        .accept_o   (accept),
        .done_o     (done_o)
    );

    pec_byte_update #(
        .CRC_W  (CRC_W),
        .DATA_W (DATA_W),
        .POLY   (POLY)
    ) u_upd (
        .seed_i (seed),
        .data_i (byte_i),
        .next_o (upd)
    );

    pec_crc_reg #(
        .CRC_W (CRC_W)
    ) u_reg (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear_i  (clear_i),
        .accept_i (accept),
        .last_i   (last_i),
        .en_i     (pec_en_i),
        .rx_i     (rx_mode_i),
        .upd_i    (upd),
        .seed_o   (seed),
        .crc_o    (crc_o),
        .ok_o     (pec_ok_o)
    );

endmodule

// File: rtl/smbus_pec_checker.sv
module smbus_pec_checker #(
    parameter int unsigned CRC_W  = 8,
    parameter int unsigned DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              clear_i,
    input logic              byte_vld_i,
    input logic [DATA_W-1:0] byte_i,
    input logic              last_i,
    input logic              pec_en_i,
    input logic              rx_mode_i,
    input logic [CRC_W-1:0]  crc_o,
    input logic              done_o,
    input logic              pec_ok_o
);

    p_clear_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (clear_i && !byte_vld_i) |=> (crc_o == '0 && !done_o));

    p_end_sets_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_vld_i && last_i && (clear_i || !done_o)) |=> done_o);

    p_hold_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !clear_i) |=> ($stable(crc_o) && done_o && $stable(pec_ok_o)));

    p_rx_verdict_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_vld_i && last_i && rx_mode_i && pec_en_i && (clear_i || !done_o))
        |=> (pec_ok_o == (crc_o == '0)));

    p_off_no_change_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!pec_en_i && !clear_i) |=> $stable(crc_o));

    p_ok_needs_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
        pec_ok_o |-> done_o);

endmodule

bind smbus_pec_engine smbus_pec_checker #(
    .CRC_W  (CRC_W),
    .DATA_W (DATA_W)
) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear_i    (clear_i),
    .byte_vld_i (byte_vld_i),
    .byte_i     (byte_i),
    .last_i     (last_i),
    .pec_en_i   (pec_en_i),
    .rx_mode_i  (rx_mode_i),
    .crc_o      (crc_o),
    .done_o     (done_o),
    .pec_ok_o   (pec_ok_o)
);

// File: tb/test_smbus_pec_engine.sv
`timescale 1ns/1ps
module test_smbus_pec_engine;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       clear = 1'b0;
    logic       bv = 1'b0;
    logic [7:0] data = 8'h00;
    logic       last = 1'b0;
    logic       en = 1'b1;
    logic       rx = 1'b0;
    logic [7:0] crc;
    logic       done;
    logic       ok;

    int n_cmp = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    smbus_pec_engine i_smbus_pec_engine (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear_i    (clear),
        .byte_vld_i (bv),
        .byte_i     (data),
        .last_i     (last),
        .pec_en_i   (en),
        .rx_mode_i  (rx),
        .crc_o      (crc),
        .done_o     (done),
        .pec_ok_o   (ok)
    );

    function automatic logic [7:0] crc8(input logic [7:0] c, input logic [7:0] b);
        logic [7:0] r;
        r = c ^ b;
        for (int i = 0; i < 8; i++) begin
            r = r[7] ? ((r << 1) ^ 8'h07) : (r << 1);
        end
        return r;
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic put(input logic c, input logic v, input logic l, input logic [7:0] d);
        @(negedge clk);
        clear = c; bv = v; last = l; data = d;
        @(posedge clk);
        #1;
        clear = 1'b0; bv = 1'b0; last = 1'b0;
    endtask

    logic [7:0] msg [4] = '{8'h16, 8'h2A, 8'h17, 8'h5C};

    initial begin
        logic [7:0] m;
        logic [7:0] good;
        #12;
        chk("R1 crc in reset", crc, 8'h00);
        chk("R1 done in reset", {7'd0, done}, 8'h00);
        chk("R1 ok in reset", {7'd0, ok}, 8'h00);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        chk("R1 crc after reset", crc, 8'h00);
        chk("R1 done after reset", {7'd0, done}, 8'h00);

        // R2/R5/R7: every single-byte message in transmit mode
        en = 1'b1; rx = 1'b0;
        for (int b = 0; b < 256; b++) begin
            put(1'b1, 1'b0, 1'b0, 8'h00);
            put(1'b0, 1'b1, 1'b1, b[7:0]);
            chk("R2 single byte crc", crc, crc8(8'h00, b[7:0]));
            chk("R5 done after end", {7'd0, done}, 8'h01);
            chk("R7 tx ok", {7'd0, ok}, 8'h01);
        end

        // R2: multi-byte with repeated address byte, checked byte by byte
        put(1'b1, 1'b0, 1'b0, 8'h00);
        chk("R3 clear zeroes", crc, 8'h00);
        chk("R3 clear drops done", {7'd0, done}, 8'h00);
        m = 8'h00;
        for (int i = 0; i < 4; i++) begin
            m = crc8(m, msg[i]);
            put(1'b0, 1'b1, i == 3, msg[i]);
            chk("R2 running crc", crc, m);
        end
        good = m;
        chk("R7 tx pec byte", crc, good);

        // R6: strobes while held are ignored
        put(1'b0, 1'b1, 1'b0, 8'hA5);
        chk("R6 crc held", crc, good);
        chk("R6 done held", {7'd0, done}, 8'h01);
        chk("R6 ok held", {7'd0, ok}, 8'h01);
        put(1'b0, 1'b1, 1'b1, 8'h3C);
        chk("R6 crc held (end flag)", crc, good);

        // R8: sweep every candidate error-code byte in receive mode
        rx = 1'b1;
        for (int p = 0; p < 256; p++) begin
            put(1'b1, 1'b0, 1'b0, 8'h00);
            for (int i = 0; i < 4; i++) put(1'b0, 1'b1, 1'b0, msg[i]);
            put(1'b0, 1'b1, 1'b1, p[7:0]);
            chk("R8 rx verdict", {7'd0, ok}, {7'd0, (p[7:0] == good)});
            chk("R8 rx residue", crc, crc8(good, p[7:0]));
        end

        // R4: clear and byte in the same cycle, from held state
        rx = 1'b0;
        put(1'b1, 1'b1, 1'b0, 8'h9E);
        chk("R4 collision from hold", crc, crc8(8'h00, 8'h9E));
        chk("R4 collision not done", {7'd0, done}, 8'h00);
        put(1'b0, 1'b1, 1'b0, 8'h41);
        m = crc8(crc8(8'h00, 8'h9E), 8'h41);
        chk("R2 after collision", crc, m);
        // R4: collision mid-message
        put(1'b1, 1'b1, 1'b0, 8'h33);
        chk("R4 collision mid message", crc, crc8(8'h00, 8'h33));
        // R3: clear mid-message
        put(1'b1, 1'b0, 1'b0, 8'h00);
        chk("R3 clear mid message", crc, 8'h00);
        // R4: collision with end flag
        put(1'b1, 1'b1, 1'b1, 8'hC8);
        chk("R4 collision with end", crc, crc8(8'h00, 8'hC8));
        chk("R4 collision with end done", {7'd0, done}, 8'h01);

        // R9: checking off
        en = 1'b0; rx = 1'b1;
        put(1'b1, 1'b0, 1'b0, 8'h00);
        for (int i = 0; i < 4; i++) begin
            put(1'b0, 1'b1, i == 3, msg[i]);
            chk("R9 crc stays zero", crc, 8'h00);
        end
        chk("R9 ok when off", {7'd0, ok}, 8'h01);
        chk("R9 done when off", {7'd0, done}, 8'h01);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #1000000;
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule